// File: doc/BRIEF.md
# Greedy Stop-Pattern Finder

This engine holds a set of ternary test slices and derives from them a stop pattern. The stop pattern is a ternary word with as few defined bits as the greedy method allows, and it differs from every stored slice in at least one defined position. A decompressor can then recognise the end of a seed by decoding only the few positions the pattern defines. Each stored slice is `SLICE_W` bits wide. Every bit carries a care flag and a value flag; a clear care flag marks a don't-care.

Software or a test controller first fills the slice store through the write port. It then pulses `start` together with the number of slices to use. The engine runs a series of passes over the slices that are still active. In each pass it counts, for every position not yet fixed, how many active slices hold a 0 there and how many hold a 1. The position and value with the largest count win. The stop bit at that position is set to the opposite value, and every active slice that holds the winning value or a don't-care at that position drops out. The passes repeat until no slice is active. `done` then rises and stays high, and the pattern appears on `stopCare` and `stopVal`.

Top module: `stopPatFinder`

## Requirements
- R1: During and right after reset, `busy`, `done` and `err` are low, and `stopCare` and `stopVal` are all zero.
- R2: A start with `sliceCount` = 0 finishes with `done` high, `err` low and `stopCare` all zero.
- R3: In each pass, the winning candidate is the one with the largest count among unfixed positions. The count for value 0 at a position is the number of active slices whose care bit is 1 and value bit is 0 there; the count for value 1 is defined the same way. Ties go to the lowest bit index first, then to value 0 before value 1.
- R4: The stop bit written at the winning position is the complement of the winning value. `stopCare` bit i = 1 marks position i as defined, and `stopVal` bit i then holds its value.
- R5: A position that is already defined in the stop pattern is never selected again in a later pass of the same run.
- R6: After a pass, a slice stays active only if its care bit at the winning position is 1 and its value there differs from the winning value. A slice that was inactive stays inactive.
- R7: If slices are still active but no unfixed position holds a defined bit in any of them, the run ends with `done` and `err` both high. The pattern fixed so far is kept.
- R8: `busy` is high from the edge after `start` until the run ends. A run with P passes over N slices keeps `busy` high for P*(N+2)+1 cycles, or for P*(N+2) cycles when it ends with an error. Once high, `done` holds, with the result stable, until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write one slice into the store |
| wrAddr | input | ADDR_W | Slice store entry to write |
| wrCare | input | SLICE_W | Care flags of the slice written (1 = defined) |
| wrVal | input | SLICE_W | Value flags of the slice written |
| start | input | 1 | Begin a run; sampled when the engine is not busy |
| sliceCount | input | CNT_W | Number of slices, entries 0 to sliceCount-1, taking part (at most MAX_SLICES) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; held until the next start |
| err | output | 1 | Run ended with active slices but no usable defined bit |
| stopCare | output | SLICE_W | Defined positions of the stop pattern |
| stopVal | output | SLICE_W | Values at the defined positions |

## Verification
A slip in the count registers or the selector shows as a wrong position or polarity in `stopCare`/`stopVal`. It appears at the first `done` after the faulty pass. A slice pruned too eagerly or too late changes both the pattern and the number of passes, so the `busy` cycle count against P*(N+2)+1 flags it in the same run even when the final pattern happens to match. A missed exclusion of fixed positions turns into a spurious error or an extra pass. The cases cover hand-built ties, don't-care pruning and the error exit, alongside many pseudo-random slice sets checked against a bench model of the greedy passes.

// File: rtl/stopPatPkg.sv
package stopPatPkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_SCAN,
    S_PICK,
    S_DONE
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPass;  // new run: reload active set, clear pattern
    logic clrCnt;    // pass begins: clear column counters
    logic scanEn;    // accumulate the slice at scanIdx
    logic pickEn;    // fix winning column and prune
  } ctrlStrobe_t;

endpackage

// File: rtl/stopPatCtrl.sv
module stopPatCtrl
  import stopPatPkg::*;
#(
  parameter int MAX_SLICES = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [CNT_W-1:0]     sliceCount,
  input  logic                 anyActive,
  input  logic                 bestValid,
  output ctrlStrobe_t          strobe,
  output logic [CNT_W-1:0]     scanIdx,
  output logic                 busy,
  output logic                 done,
  output logic                 err
);
  localparam int CNT_W = $clog2(MAX_SLICES + 1);

  ctrlState_t       state;
  logic [CNT_W-1:0] nSlices;
  logic             idleLike;

  assign idleLike = (state == S_IDLE) || (state == S_DONE);
  assign busy     = (state == S_CHECK) || (state == S_SCAN) || (state == S_PICK);

  always_comb begin
    strobe          = '0;
    strobe.loadPass = idleLike && start;
    strobe.clrCnt   = (state == S_CHECK);
    strobe.scanEn   = (state == S_SCAN);
    strobe.pickEn   = (state == S_PICK) && bestValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      nSlices <= '0;
      scanIdx <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      case (state)
        S_IDLE, S_DONE: begin
          if (start) begin
            state   <= S_CHECK;
            nSlices <= sliceCount;
            done    <= 1'b0;
            err     <= 1'b0;
          end
        end
        S_CHECK: begin
          scanIdx <= '0;
          if (anyActive) begin
            state <= S_SCAN;
          end else begin
            state <= S_DONE;
            done  <= 1'b1;
          end
        end
        S_SCAN: begin
          if (scanIdx == nSlices - CNT_W'(1)) state <= S_PICK;
          else scanIdx <= scanIdx + CNT_W'(1);
        end
        S_PICK: begin
          if (bestValid) begin
            state <= S_CHECK;
          end else begin
            state <= S_DONE;
            done  <= 1'b1;
            err   <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7: an error is only ever reported at the end of a run
  a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done);

  // R8: busy and done never overlap
  a_r8_busy_excl_done: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R8: done holds until a new start is accepted
  a_r8_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

endmodule

// File: rtl/stopPatData.sv
module stopPatData
  import stopPatPkg::*;
#(
  parameter int SLICE_W    = 10,
  parameter int MAX_SLICES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [SLICE_W-1:0] wrCare,
  input  logic [SLICE_W-1:0] wrVal,
  input  logic [CNT_W-1:0]   sliceCount,
  input  ctrlStrobe_t        strobe,
  input  logic [CNT_W-1:0]   scanIdx,
  output logic               anyActive,
  output logic               bestValid,
  output logic [SLICE_W-1:0] stopCare,
  output logic [SLICE_W-1:0] stopVal
);
  localparam int CNT_W  = $clog2(MAX_SLICES + 1);
  localparam int ADDR_W = (MAX_SLICES > 1) ? $clog2(MAX_SLICES) : 1;
  localparam int COL_W  = (SLICE_W > 1) ? $clog2(SLICE_W) : 1;

  logic [SLICE_W-1:0]    careMem [MAX_SLICES];
  logic [SLICE_W-1:0]    valMem  [MAX_SLICES];
  logic [MAX_SLICES-1:0] active;
  logic [CNT_W-1:0]      zeroCnt [SLICE_W];
  logic [CNT_W-1:0]      oneCnt  [SLICE_W];
  logic [SLICE_W-1:0]    curCare;
  logic [SLICE_W-1:0]    curVal;
  logic                  curActive;
  logic [CNT_W-1:0]      bestCnt;
  logic [COL_W-1:0]      bestCol;
  logic                  bestVal;

  // slice store
  always_ff @(posedge clk) begin
    if (wrEn) begin
      careMem[wrAddr] <= wrCare;
      valMem[wrAddr]  <= wrVal;
    end
  end

  assign curCare   = careMem[scanIdx[ADDR_W-1:0]];
  assign curVal    = valMem[scanIdx[ADDR_W-1:0]];
  assign curActive = active[scanIdx[ADDR_W-1:0]];
  assign anyActive = |active;

  // active set, one flag per stored slice
  for (genvar gi = 0; gi < MAX_SLICES; gi++) begin : gActive
    always_ff @(posedge clk) begin
      if (!rstN) begin
        active[gi] <= 1'b0;
      end else if (strobe.loadPass) begin
        active[gi] <= (CNT_W'(gi) < sliceCount);
      end else if (strobe.pickEn) begin
        active[gi] <= active[gi] & careMem[gi][bestCol] &
                      (valMem[gi][bestCol] != bestVal);
      end
    end
  end

  // per-column counts of defined zeros and ones among active slices
  for (genvar gc = 0; gc < SLICE_W; gc++) begin : gCount
    always_ff @(posedge clk) begin
      if (!rstN || strobe.clrCnt) begin
        zeroCnt[gc] <= '0;
        oneCnt[gc]  <= '0;
      end else if (strobe.scanEn && curActive && curCare[gc]) begin
        if (curVal[gc]) oneCnt[gc] <= oneCnt[gc] + CNT_W'(1);
        else            zeroCnt[gc] <= zeroCnt[gc] + CNT_W'(1);
      end
    end

    // R3: a column can never count more defined bits than slices exist
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rstN)
      ({1'b0, zeroCnt[gc]} + {1'b0, oneCnt[gc]}) <= (CNT_W + 1)'(MAX_SLICES));
  end

  // winner: strict compare in ascending order -> low index, then value 0
  always_comb begin
    bestCnt = '0;
    bestCol = '0;
    bestVal = 1'b0;
    for (int c = 0; c < SLICE_W; c++) begin
      if (!stopCare[c]) begin
        if (zeroCnt[c] > bestCnt) begin
          bestCnt = zeroCnt[c];
          bestCol = COL_W'(c);
          bestVal = 1'b0;
        end
        if (oneCnt[c] > bestCnt) begin
          bestCnt = oneCnt[c];
          bestCol = COL_W'(c);
          bestVal = 1'b1;
        end
      end
    end
  end
  assign bestValid = (bestCnt != '0);

  // stop pattern
  always_ff @(posedge clk) begin
    if (!rstN || strobe.loadPass) begin
      stopCare <= '0;
      stopVal  <= '0;
    end else if (strobe.pickEn) begin
      stopCare[bestCol] <= 1'b1;
      stopVal[bestCol]  <= ~bestVal;
    end
  end

  // R4: each fixing pass defines exactly one new position
  a_r4_one_bit_per_pass: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pickEn |=> ($countones(stopCare) == $past($countones(stopCare)) + 1));

  // R4: the new stop bit opposes the winning value
  a_r4_complement: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pickEn |=> (stopVal[$past(bestCol)] != $past(bestVal)));

  // R5: defined positions are never released within a run
  a_r5_fixed_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadPass |=> ((stopCare & $past(stopCare)) == $past(stopCare)));

  // R6: every fixing pass removes at least one active slice
  a_r6_prune_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pickEn |=> ($countones(active) < $past($countones(active))));

endmodule

// File: rtl/stopPatFinder.sv
module stopPatFinder
  import stopPatPkg::*;
#(
  parameter int SLICE_W    = 10,
  parameter int MAX_SLICES = 16,
  localparam int CNT_W  = $clog2(MAX_SLICES + 1),
  localparam int ADDR_W = (MAX_SLICES > 1) ? $clog2(MAX_SLICES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [SLICE_W-1:0] wrCare,
  input  logic [SLICE_W-1:0] wrVal,
  input  logic               start,
  input  logic [CNT_W-1:0]   sliceCount,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [SLICE_W-1:0] stopCare,
  output logic [SLICE_W-1:0] stopVal
);
  ctrlStrobe_t      strobe;
  logic [CNT_W-1:0] scanIdx;
  logic             anyActive;
  logic             bestValid;

  stopPatCtrl #(.MAX_SLICES(MAX_SLICES)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .sliceCount (sliceCount),
    .anyActive  (anyActive),
    .bestValid  (bestValid),
    .strobe     (strobe),
    .scanIdx    (scanIdx),
    .busy       (busy),
    .done       (done),
    .err        (err)
  );

  stopPatData #(.SLICE_W(SLICE_W), .MAX_SLICES(MAX_SLICES)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrCare     (wrCare),
    .wrVal      (wrVal),
    .sliceCount (sliceCount),
    .strobe     (strobe),
    .scanIdx    (scanIdx),
    .anyActive  (anyActive),
    .bestValid  (bestValid),
    .stopCare   (stopCare),
    .stopVal    (stopVal)
  );

endmodule

// File: tb/stopPatFinder_test.sv
module stopPatFinder_test;
  localparam int W  = 10;
  localparam int M  = 16;
  localparam int CW = $clog2(M + 1);
  localparam int AW = $clog2(M);

  typedef struct {
    logic [W-1:0] care;
    logic [W-1:0] val;
    logic         err;
    int           busyCyc;
    string        tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [W-1:0]  wrCare = '0;
  logic [W-1:0]  wrVal = '0;
  logic          start = 1'b0;
  logic [CW-1:0] sliceCount = '0;
  logic          busy, done, err;
  logic [W-1:0]  stopCare, stopVal;

  logic [W-1:0]  mCare [M];
  logic [W-1:0]  mVal  [M];
  exp_t          sb[$];
  int            nChk = 0;
  int            nBad = 0;
  int            busyCnt = 0;
  logic          prevDone = 1'b0;
  logic          monOn = 1'b0;
  logic          finished = 1'b0;

  always #10 clk = ~clk;

  stopPatFinder #(.SLICE_W(W), .MAX_SLICES(M)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrCare(wrCare),
    .wrVal(wrVal), .start(start), .sliceCount(sliceCount), .busy(busy),
    .done(done), .err(err), .stopCare(stopCare), .stopVal(stopVal)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // greedy reference built from the requirements
  function automatic exp_t refModel(input int n);
    exp_t         e;
    logic [M-1:0] act;
    logic [W-1:0] fc, fv;
    int           passes, bc, bcol;
    logic         bv;
    act = '0;
    for (int i = 0; i < n; i++) act[i] = 1'b1;
    fc = '0; fv = '0; passes = 0; e.err = 1'b0;
    while (act != '0) begin
      passes++;
      bc = 0; bcol = 0; bv = 1'b0;
      for (int c = 0; c < W; c++) begin
        int z, o;
        z = 0; o = 0;
        if (!fc[c]) begin
          for (int i = 0; i < M; i++)
            if (act[i] && mCare[i][c]) begin
              if (mVal[i][c]) o++; else z++;
            end
          if (z > bc) begin bc = z; bcol = c; bv = 1'b0; end
          if (o > bc) begin bc = o; bcol = c; bv = 1'b1; end
        end
      end
      if (bc == 0) begin
        e.err = 1'b1;
        break;
      end
      fc[bcol] = 1'b1;
      fv[bcol] = ~bv;
      for (int i = 0; i < M; i++)
        if (act[i] && (!mCare[i][bcol] || mVal[i][bcol] == bv)) act[i] = 1'b0;
    end
    e.care = fc;
    e.val = fv;
    e.busyCyc = e.err ? passes * (n + 2) : passes * (n + 2) + 1;
    return e;
  endfunction

  task automatic clrSlices();
    for (int i = 0; i < M; i++) begin
      mCare[i] = '0;
      mVal[i] = '0;
    end
  endtask

  task automatic setBit(input int s, input int pos, input logic v);
    mCare[s][pos] = 1'b1;
    mVal[s][pos] = v;
  endtask

  // driver: load slices, push expectation, start, wait for finish
  task automatic runCase(input int n, input string tag);
    exp_t e;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrEn = 1'b1; wrAddr = AW'(i); wrCare = mCare[i]; wrVal = mVal[i];
    end
    @(negedge clk);
    wrEn = 1'b0;
    e = refModel(n);
    e.tag = tag;
    sb.push_back(e);
    sliceCount = CW'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done == 1'b1 && stopCare == e.care, {"R8 done held ", tag},
        {22'd0, done, stopCare[8:0]}, {22'd0, 1'b1, e.care[8:0]});
  endtask

  // monitor: compare each finished run with the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      if (monOn) begin
        if (busy) busyCnt++;
        if (done && !prevDone) begin
          exp_t e;
          if (sb.size() == 0) begin
            chk(1'b0, "R8 unexpected done", 32'd1, 32'd0);
          end else begin
            e = sb.pop_front();
            chk(stopCare == e.care, {"R3 R5 R6 stopCare ", e.tag},
                32'(stopCare), 32'(e.care));
            chk((stopVal & stopCare) == e.val, {"R4 stopVal ", e.tag},
                32'(stopVal & stopCare), 32'(e.val));
            chk(err == e.err, {"R7 err ", e.tag}, 32'(err), 32'(e.err));
            chk(busyCnt == e.busyCyc, {"R8 busy cycles ", e.tag},
                32'(busyCnt), 32'(e.busyCyc));
          end
          busyCnt = 0;
        end
        prevDone = done;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    clrSlices();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R1 flags in reset",
        {29'd0, busy, done, err}, 32'd0);
    chk(stopCare == '0 && stopVal == '0, "R1 pattern in reset",
        32'(stopCare | stopVal), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R1 flags after reset",
        {29'd0, busy, done, err}, 32'd0);
    monOn = 1'b1;

    // R2: empty set -> done, no pattern, one busy cycle
    runCase(0, "R2 empty");

    // R6: x at the winning column drops a slice; expect care=001 val=001
    clrSlices();
    setBit(0, 0, 1'b0); setBit(1, 0, 1'b0); setBit(2, 3, 1'b1);
    runCase(3, "R6 x pruned");

    // R3: equal counts in two columns -> lower index wins (care=val=004)
    clrSlices();
    setBit(0, 2, 1'b0); setBit(1, 5, 1'b1);
    runCase(2, "R3 column tie");

    // R7/R5: value tie in one column, 0 wins; leftover slice only has the fixed bit
    clrSlices();
    setBit(0, 4, 1'b0); setBit(1, 4, 1'b1);
    runCase(2, "R7 error exit");

    // R4: two passes; expect care bits 1 and 7, both stop values 0
    clrSlices();
    setBit(0, 1, 1'b0); setBit(0, 7, 1'b1);
    setBit(1, 1, 1'b0); setBit(1, 7, 1'b1);
    setBit(2, 1, 1'b1); setBit(2, 7, 1'b1);
    setBit(3, 1, 1'b1); setBit(3, 7, 1'b0);
    runCase(4, "R4 two passes");

    // R3 R5 R6: full store of dense slices
    clrSlices();
    for (int i = 0; i < M; i++) begin
      mCare[i] = W'(10'h3FF);
      mVal[i] = W'(i * 37 + 5);
    end
    runCase(M, "R3 full dense");

    // pseudo-random sets of varying size and density
    void'($urandom(32'h5eed));
    for (int k = 0; k < 40; k++) begin
      int n;
      clrSlices();
      n = $urandom_range(1, M);
      for (int i = 0; i < n; i++) begin
        logic [W-1:0] cm;
        cm = W'($urandom);
        if (k % 2 == 0) cm = cm & W'($urandom);
        mCare[i] = cm;
        mVal[i] = W'($urandom);
      end
      runCase(n, $sformatf("R3 random %0d", k));
    end

    repeat (2) @(negedge clk);
    chk(sb.size() == 0, "R8 all runs finished", 32'(sb.size()), 32'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

endmodule